// File: doc/BRIEF.md
# Serial Address Loader with One-Hot Channel Select

This block gathers a channel address from a single serial line and turns it into one enable per channel. On every clock the serial input moves into a short chain of flip-flops. The live input acts as the least significant address bit, so a chain of n stages plus the input gives an (n+1)-bit address. The bit received first is the most significant bit.

When the commit strobe is high at a clock edge, the full address (the chain contents plus the live input) is copied into an address register. The block decodes the stored address into 2^(n+1) enable lines.

Each channel has one term per address bit. A term is satisfied by a 1 on that bit for some channels and by a 0 for the others. A channel is enabled only when all of its terms hold, so exactly one channel is enabled at any time. The selection stays in place until the next commit. Reset clears the stored address and therefore selects channel 0.

Top module: `serial_chan_sel`

## Requirements
- R1: A synchronous active-high reset clears the address register to zero, so after reset only enable bit 0 is high.
- R2: The serial input shifts into the chain on every clock edge. The address seen at a commit is {older chain bits, live input}, where the first-received bit is the MSB and the live input is bit 0.
- R3: On a clock edge with commit high, the address register takes the address. The enable bit at the index equal to that address, read as unsigned binary, is then the only enable bit high.
- R4: While commit is low, the address register and the enables keep their values, whatever the serial input does.
- R5: Exactly one enable bit is high in every cycle after reset.
- R6: An all-ones address enables only the highest channel (index 2^W-1). An all-zeros address enables only channel 0.
- R7: Bits shifted in more than SHIFT_STAGES cycles before a commit fall off the chain and do not affect the committed address.
- R8: Commits on consecutive cycles each latch the address present in their own cycle, and the chain keeps shifting through them.
- R9: The address width is SHIFT_STAGES+1 (default 2 stages, 3 bits), and the block has 2^(SHIFT_STAGES+1) enable outputs (default 8).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_in | input | 1 | Serial address bit, MSB first; also the live address LSB |
| commit | input | 1 | Latch the current address at this clock edge |
| addr_q | output | SHIFT_STAGES+1 | Latched address |
| chan_en | output | 2^(SHIFT_STAGES+1) | One-hot channel enables |

## Verification
Four properties are checked on every cycle:
- the enables are one-hot;
- the enable at the latched index is high;
- the end channels match the all-zeros and all-ones addresses;
- without a commit, the address and enables stay the same; with a commit, bit 0 of the new address equals the previous cycle's serial input.

The bench scenarios cover the behaviours that depend on sequence. These are the MSB-first ordering across several cycles, stale bits falling out of the chain, back-to-back commits, and a reset that clears an address already held.

// File: rtl/chan_sel_pkg.sv
package chan_sel_pkg;

    // Polarity of one per-bit term of a channel's enable product
    typedef enum logic {
        TERM_ON_ZERO = 1'b0,
        TERM_ON_ONE  = 1'b1
    } term_pol_e;

    // Polarity that channel `chan` needs on address bit `bitpos`
    function automatic term_pol_e term_pol(input int unsigned chan, input int unsigned bitpos);
        logic [31:0] c;
        c = chan;
        return c[bitpos] ? TERM_ON_ONE : TERM_ON_ZERO;
    endfunction

    // Whether an address bit satisfies a term of the given polarity
    function automatic logic term_hit(input term_pol_e pol, input logic abit);
        return (pol == TERM_ON_ONE) ? abit : ~abit;
    endfunction

endpackage

// File: rtl/ser_shift_chain.sv
module ser_shift_chain #(
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ser_in,
    output logic [STAGES-1:0] hist
);
    // hist[0] holds the newest stored bit, hist[STAGES-1] the oldest
    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        logic d;
        if (k == 0) begin : g_first
            assign d = ser_in;
        end else begin : g_next
            assign d = hist[k-1];
        end
        always_ff @(posedge clk) begin
            if (rst) hist[k] <= 1'b0;
            else     hist[k] <= d;
        end
    end
endmodule

// File: rtl/addr_latch.sv
module addr_latch #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)       q <= '0;
        else if (load) q <= d;
    end
endmodule

// File: rtl/onehot_decode.sv
module onehot_decode
    import chan_sel_pkg::*;
#(
    parameter int W = 3,
    parameter int N = 1 << W
) (
    input  logic [W-1:0] addr,
    output logic [N-1:0] en
);
    for (genvar c = 0; c < N; c++) begin : g_chan
        logic [W-1:0] terms;
        for (genvar b = 0; b < W; b++) begin : g_term
            localparam term_pol_e POL = term_pol(c, b);
            assign terms[b] = term_hit(POL, addr[b]);
        end
        assign en[c] = &terms;
    end
endmodule

// File: rtl/serial_chan_sel.sv
module serial_chan_sel #(
    parameter  int SHIFT_STAGES = 2,
    localparam int ADDR_W       = SHIFT_STAGES + 1,
    localparam int CHANS        = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ser_in,
    input  logic              commit,
    output logic [ADDR_W-1:0] addr_q,
    output logic [CHANS-1:0]  chan_en
);
    logic [SHIFT_STAGES-1:0] hist;
    logic [ADDR_W-1:0]       addr_now;

    ser_shift_chain #(.STAGES(SHIFT_STAGES)) chain_i (
        .clk    (clk),
        .rst    (rst),
        .ser_in (ser_in),
        .hist   (hist)
    );

    // Oldest stored bit is the MSB; the live input is the LSB
    always_comb begin
        for (int i = 0; i < SHIFT_STAGES; i++) begin
            addr_now[ADDR_W-1-i] = hist[SHIFT_STAGES-1-i];
        end
        addr_now[0] = ser_in;
    end

    addr_latch #(.W(ADDR_W)) latch_i (
        .clk  (clk),
        .rst  (rst),
        .load (commit),
        .d    (addr_now),
        .q    (addr_q)
    );

    onehot_decode #(.W(ADDR_W), .N(CHANS)) dec_i (
        .addr (addr_q),
        .en   (chan_en)
    );
endmodule

// File: rtl/serial_chan_sel_chk.sv
module serial_chan_sel_chk #(
    parameter int ADDR_W = 3,
    parameter int CHANS  = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              ser_in,
    input logic              commit,
    input logic [ADDR_W-1:0] addr_q,
    input logic [CHANS-1:0]  chan_en
);
    // R1
    reset_clear_chk: assert property (@(posedge clk) rst |=> (addr_q == '0));

    // R5
    one_hot_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(chan_en) == 1);

    // R3
    index_match_chk: assert property (@(posedge clk) disable iff (rst)
        chan_en[addr_q] == 1'b1);

    // R4
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !commit |=> ($stable(addr_q) && $stable(chan_en)));

    // R2
    lsb_tap_chk: assert property (@(posedge clk) disable iff (rst)
        commit |=> (addr_q[0] == $past(ser_in)));

    // R6
    bottom_chan_chk: assert property (@(posedge clk) disable iff (rst)
        (addr_q == '0) == chan_en[0]);

    // R6
    top_chan_chk: assert property (@(posedge clk) disable iff (rst)
        (addr_q == '1) == chan_en[CHANS-1]);
endmodule

bind serial_chan_sel serial_chan_sel_chk #(.ADDR_W(ADDR_W), .CHANS(CHANS)) chk_i (
    .clk     (clk),
    .rst     (rst),
    .ser_in  (ser_in),
    .commit  (commit),
    .addr_q  (addr_q),
    .chan_en (chan_en)
);

// File: tb/serial_chan_sel_tb_top.sv
`timescale 1ns/1ps
module serial_chan_sel_tb_top;
    localparam int AW = 3;
    localparam int NC = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ser_in = 1'b0;
    logic          commit = 1'b0;
    logic [AW-1:0] addr_q;
    logic [NC-1:0] chan_en;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    // 200 MHz clock
    always #2.5 clk = ~clk;

    serial_chan_sel #(.SHIFT_STAGES(2)) dut_i (
        .clk     (clk),
        .rst     (rst),
        .ser_in  (ser_in),
        .commit  (commit),
        .addr_q  (addr_q),
        .chan_en (chan_en)
    );

    // Each entry: {address, expected enables}
    localparam logic [AW+NC-1:0] VEC [8] = '{
        {3'd5, 8'h20}, {3'd0, 8'h01}, {3'd7, 8'h80}, {3'd2, 8'h04},
        {3'd6, 8'h40}, {3'd1, 8'h02}, {3'd3, 8'h08}, {3'd4, 8'h10}
    };

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    // Drive one bit for the coming edge; return after the edge at the next negedge
    task automatic put_bit(input logic b, input logic c);
        ser_in = b;
        commit = c;
        @(negedge clk);
        commit = 1'b0;
    endtask

    task automatic load_addr(input logic [AW-1:0] a);
        put_bit(a[2], 1'b0);
        put_bit(a[1], 1'b0);
        put_bit(a[0], 1'b1);
    endtask

    initial begin
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check("R1 reset addr", 32'(addr_q), 32'd0);
        check("R1 reset enables", 32'(chan_en), 32'h01);

        // R3 R9 table walk
        for (int i = 0; i < 8; i++) begin
            load_addr(VEC[i][AW+NC-1:NC]);
            check("R3 addr", 32'(addr_q), 32'(VEC[i][AW+NC-1:NC]));
            check("R3 enables", 32'(chan_en), 32'(VEC[i][NC-1:0]));
            check("R5 onehot", 32'($countones(chan_en)), 32'd1);
        end

        // R6 ends
        load_addr(3'd7);
        check("R6 all ones", 32'(chan_en), 32'h80);
        load_addr(3'd0);
        check("R6 all zeros", 32'(chan_en), 32'h01);

        // R4 hold without commit
        load_addr(3'd5);
        put_bit(1'b0, 1'b0);
        put_bit(1'b1, 1'b0);
        put_bit(1'b1, 1'b0);
        put_bit(1'b0, 1'b0);
        check("R4 hold addr", 32'(addr_q), 32'd5);
        check("R4 hold enables", 32'(chan_en), 32'h20);

        // R7 stale bits drop out: 1,1,0,0,1 -> 001
        put_bit(1'b1, 1'b0);
        put_bit(1'b1, 1'b0);
        put_bit(1'b0, 1'b0);
        put_bit(1'b0, 1'b0);
        put_bit(1'b1, 1'b1);
        check("R7 stale bits", 32'(chan_en), 32'h02);

        // R8 back-to-back commits: chain {0,1}, then 1 -> 011, then 0 -> 110
        put_bit(1'b1, 1'b1);
        check("R8 first commit", 32'(addr_q), 32'd3);
        put_bit(1'b0, 1'b1);
        check("R8 second commit", 32'(addr_q), 32'd6);
        check("R8 enables", 32'(chan_en), 32'h40);

        // R2 MSB-first ordering
        load_addr(3'b100);
        check("R2 msb first", 32'(chan_en), 32'h10);

        // R1 reset mid-run
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 reset clears", 32'(chan_en), 32'h01);

        // R1 chain cleared: commit right after reset with input 0 gives 000
        put_bit(1'b0, 1'b1);
        check("R1 chain cleared", 32'(addr_q), 32'd0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule